// File: doc/BRIEF.md
# Permission Lookaside Buffer with Masked Tags

This block is a small, fully associative cache that sits beside the load/store path. It holds recently used entries of a per-word permissions table. Every memory reference looks it up by word address and gets back a hit flag and a 2-bit access code. Each entry carries a tag and a count of low address bits that the comparison ignores. A single entry can therefore stand for an aligned block of 2^n words, which keeps the miss rate low when protected regions are large.

Entries come in through a fill port, which the table walker drives after a miss. On a fill, a free slot is used if there is one; otherwise a rotating pointer picks the slot. When software changes permissions, the stale copies must be gone before the next reference. A region invalidate does this by taking an address and a masked-bit count and clearing every overlapping entry in one clock. A flush empties the whole buffer.

Top module: `rights_lookaside`

## Requirements
- R1: An entry matches a lookup address when the address and the entry's tag are equal in every bit at or above the entry's masked count. The low `count` bits are ignored, and a count of ADDR_W or more matches every address.
- R2: The access code is 2 bits: 2'b00 no access, 2'b01 read-only, 2'b10 read-write, 2'b11 execute-read. A hit returns the code stored by the fill that created the matching entry.
- R3: The result is registered. A request sampled at a rising edge sets `lk_hit`/`lk_perm` right after that edge. At an edge with no request, `lk_hit` goes to 0 and `lk_perm` keeps its value.
- R4: A request that matches no valid entry gives `lk_hit`=0 and `lk_perm`=2'b00.
- R5: When several valid entries match, the one with the lowest slot index supplies the code.
- R6: A fill goes into the lowest-indexed invalid slot whenever one exists.
- R7: When every slot is valid, a fill replaces the slot named by a rotating pointer. The pointer starts at slot 0 after reset and steps by one, wrapping after the last slot. It steps only on fills that used it.
- R8: An invalidate clears, in one edge, every valid entry whose block overlaps the given region. Overlap means the tag and the invalidate address agree in every bit at or above the larger of the two masked counts. A lookup in the next cycle already sees the entries cleared.
- R9: A flush clears every entry in one edge.
- R10: A fill in the same cycle as an invalidate or flush is dropped. A lookup in the same cycle as any fill, invalidate or flush sees the contents from before that edge.
- R11: After reset all slots are invalid, `lk_hit` is 0 and `lk_perm` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Word address to look up |
| lk_hit | output | 1 | Registered hit flag |
| lk_perm | output | 2 | Registered access code |
| fill_en | input | 1 | Write one entry |
| fill_addr | input | ADDR_W | Tag of the new entry |
| fill_mcnt | input | MCNT_W | Count of ignored low tag bits |
| fill_perm | input | 2 | Access code of the new entry |
| inv_en | input | 1 | Region invalidate |
| inv_addr | input | ADDR_W | Region base address |
| inv_mcnt | input | MCNT_W | Count of ignored low bits of the region |
| flush_en | input | 1 | Clear every entry |

## Verification
Two cases are hard to reach from the ports. The first is the rotating-pointer replacement, which only happens once the buffer is full. The second is a freed slot being reused ahead of the pointer after an invalidate has opened a hole. The bench uses a 4-slot, 8-bit-address build. It fills beyond capacity, punches a hole with a narrow invalidate that overlaps a wide entry, and then refills. After each step it sweeps all 256 addresses and compares against a shift-based model of the block. Nested entries with different widths check the lowest-index rule. Invalidates issued in the same cycle as a lookup or a fill check the same-edge ordering.

// File: rtl/rl_pkg.sv
package rl_pkg;
  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b10,
    PERM_XR   = 2'b11
  } perm_e;
endpackage

// File: rtl/rl_store.sv
module rl_store #(
  parameter int ENTRIES = 60,
  parameter int ADDR_W  = 30,
  parameter int MCNT_W  = 5,
  parameter int IDX_W   = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [ADDR_W-1:0]                wr_tag,
  input  logic [MCNT_W-1:0]                wr_mcnt,
  input  logic [1:0]                       wr_perm,
  input  logic [ENTRIES-1:0]               clr_vec,
  input  logic                             flush,
  output logic [ENTRIES-1:0]               valid_o,
  output logic [ENTRIES-1:0][ADDR_W-1:0]   tag_o,
  output logic [ENTRIES-1:0][MCNT_W-1:0]   mcnt_o,
  output logic [ENTRIES-1:0][1:0]          perm_o
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    logic sel_w;
    logic valid_d;

    assign sel_w = wr_en && (wr_idx == IDX_W'(e));

    always_comb begin
      valid_d = valid_o[e];
      if (flush || clr_vec[e]) valid_d = 1'b0;
      else if (sel_w)          valid_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_o[e] <= 1'b0;
      else        valid_o[e] <= valid_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_o[e]  <= '0;
        mcnt_o[e] <= '0;
        perm_o[e] <= '0;
      end else if (sel_w) begin
        tag_o[e]  <= wr_tag;
        mcnt_o[e] <= wr_mcnt;
        perm_o[e] <= wr_perm;
      end
    end
  end

endmodule

// File: rtl/rl_match.sv
module rl_match #(
  parameter int ENTRIES = 60,
  parameter int ADDR_W  = 30,
  parameter int MCNT_W  = 5
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] tag,
  input  logic [ENTRIES-1:0][MCNT_W-1:0] mcnt,
  input  logic [ADDR_W-1:0]              lk_addr,
  input  logic [ADDR_W-1:0]              inv_addr,
  input  logic [MCNT_W-1:0]              inv_mcnt,
  output logic [ENTRIES-1:0]             hit_vec,
  output logic [ENTRIES-1:0]             kill_vec
);

  function automatic logic [ADDR_W-1:0] low_ones(input logic [MCNT_W-1:0] c);
    logic [ADDR_W-1:0] m;
    for (int i = 0; i < ADDR_W; i++)
      m[i] = ({{(32-MCNT_W){1'b0}}, c} > 32'(i));
    return m;
  endfunction

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    logic [ADDR_W-1:0] own_m;
    logic [ADDR_W-1:0] wide_m;

    assign own_m  = low_ones(mcnt[e]);
    assign wide_m = (mcnt[e] > inv_mcnt) ? own_m : low_ones(inv_mcnt);

    assign hit_vec[e]  = valid[e] && (((lk_addr  ^ tag[e]) & ~own_m)  == '0);
    assign kill_vec[e] = valid[e] && (((inv_addr ^ tag[e]) & ~wide_m) == '0);
  end

endmodule

// File: rtl/rl_victim.sv
module rl_victim #(
  parameter int ENTRIES = 60,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid,
  input  logic               fill_go,
  output logic [IDX_W-1:0]   vict_idx
);

  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx;
  logic             have_free;
  logic             rr_en;

  always_comb begin
    free_idx  = '0;
    have_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx  = IDX_W'(i);
        have_free = 1'b1;
      end
    end
  end

  assign vict_idx = have_free ? free_idx : rr_q;
  assign rr_en    = fill_go && !have_free;

  always_comb begin
    if (rr_q == IDX_W'(ENTRIES - 1)) rr_d = '0;
    else                             rr_d = rr_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (rr_en) rr_q <= rr_d;
  end

endmodule

// File: rtl/rights_lookaside.sv
module rights_lookaside
  import rl_pkg::*;
#(
  parameter int ENTRIES = 60,
  parameter int ADDR_W  = 30,
  parameter int MCNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [1:0]        lk_perm,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [MCNT_W-1:0] fill_mcnt,
  input  logic [1:0]        fill_perm,
  input  logic              inv_en,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic [MCNT_W-1:0] inv_mcnt,
  input  logic              flush_en
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             valid;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag;
  logic [ENTRIES-1:0][MCNT_W-1:0] mcnt;
  logic [ENTRIES-1:0][1:0]        perm;
  logic [ENTRIES-1:0]             hit_vec;
  logic [ENTRIES-1:0]             kill_vec;
  logic [ENTRIES-1:0]             clr_vec;
  logic [IDX_W-1:0]               vict_idx;
  logic                           fill_go;

  // Maintenance wins over a fill issued in the same cycle.
  assign fill_go = fill_en && !inv_en && !flush_en;
  assign clr_vec = inv_en ? kill_vec : '0;

  rl_store #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .MCNT_W(MCNT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fill_go), .wr_idx(vict_idx),
    .wr_tag(fill_addr), .wr_mcnt(fill_mcnt), .wr_perm(fill_perm),
    .clr_vec(clr_vec), .flush(flush_en),
    .valid_o(valid), .tag_o(tag), .mcnt_o(mcnt), .perm_o(perm)
  );

  rl_match #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .MCNT_W(MCNT_W)
  ) u_match (
    .valid(valid), .tag(tag), .mcnt(mcnt),
    .lk_addr(lk_addr), .inv_addr(inv_addr), .inv_mcnt(inv_mcnt),
    .hit_vec(hit_vec), .kill_vec(kill_vec)
  );

  rl_victim #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_victim (
    .clk(clk), .rst_n(rst_n),
    .valid(valid), .fill_go(fill_go), .vict_idx(vict_idx)
  );

  // Lowest slot index takes priority among multiple hits.
  perm_e sel_perm;
  always_comb begin
    sel_perm = PERM_NONE;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) sel_perm = perm_e'(perm[i]);
  end

  logic       hit_d, hit_q;
  logic [1:0] perm_d, perm_q;
  logic       perm_en;

  assign perm_en = lk_req;
  assign hit_d   = lk_req && (|hit_vec);
  assign perm_d  = sel_perm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       perm_q <= 2'b00;
    else if (perm_en) perm_q <= perm_d;
  end

  assign lk_hit  = hit_q;
  assign lk_perm = perm_q;

endmodule

// File: rtl/rl_checker.sv
module rl_checker #(
  parameter int ADDR_W = 30,
  parameter int MCNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_req,
  input logic              lk_hit,
  input logic [1:0]        lk_perm,
  input logic              fill_en,
  input logic              inv_en,
  input logic [MCNT_W-1:0] inv_mcnt,
  input logic              flush_en
);

  // Tracks whether any fill could have landed since the buffer was last emptied.
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (flush_en || (inv_en && int'(inv_mcnt) >= ADDR_W)) seen_q <= 1'b0;
    else if (fill_en && !inv_en) seen_q <= 1'b1;
  end

  // R3
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_hit);

  // R3
  idle_perm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> $stable(lk_perm));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en ##1 lk_req) |=> !lk_hit);

  // R11
  empty_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !seen_q) |=> !lk_hit);

  // R4
  miss_code_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !seen_q) |=> (lk_perm == 2'b00));

endmodule

bind rights_lookaside rl_checker #(.ADDR_W(ADDR_W), .MCNT_W(MCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_hit(lk_hit),
  .lk_perm(lk_perm), .fill_en(fill_en), .inv_en(inv_en),
  .inv_mcnt(inv_mcnt), .flush_en(flush_en)
);

// File: tb/tb_rights_lookaside.sv
module tb_rights_lookaside;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int MW = 4;

  logic          clk, rst_n;
  logic          lk_req;
  logic [AW-1:0] lk_addr;
  logic          lk_hit;
  logic [1:0]    lk_perm;
  logic          fill_en;
  logic [AW-1:0] fill_addr;
  logic [MW-1:0] fill_mcnt;
  logic [1:0]    fill_perm;
  logic          inv_en;
  logic [AW-1:0] inv_addr;
  logic [MW-1:0] inv_mcnt;
  logic          flush_en;

  rights_lookaside #(.ENTRIES(N), .ADDR_W(AW), .MCNT_W(MW)) dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // Bench model of the slots.
  bit m_v [N];
  int m_tag [N];
  int m_mc [N];
  int m_p [N];
  int m_rr;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mdl_hit(input int a);
    for (int e = 0; e < N; e++)
      if (m_v[e] && (((a ^ m_tag[e]) >> m_mc[e]) == 0)) return 1;
    return 0;
  endfunction

  function automatic int mdl_perm(input int a);
    for (int e = 0; e < N; e++)
      if (m_v[e] && (((a ^ m_tag[e]) >> m_mc[e]) == 0)) return m_p[e];
    return 0;
  endfunction

  task automatic do_fill(input int a, input int mc, input int p);
    int slot;
    slot = -1;
    fill_en = 1; fill_addr = AW'(a); fill_mcnt = MW'(mc); fill_perm = 2'(p);
    @(negedge clk);
    fill_en = 0;
    for (int e = N - 1; e >= 0; e--) if (!m_v[e]) slot = e;
    if (slot < 0) begin
      slot = m_rr;
      m_rr = (m_rr + 1) % N;
    end
    m_v[slot] = 1; m_tag[slot] = a; m_mc[slot] = mc; m_p[slot] = p;
  endtask

  task automatic mdl_inv(input int a, input int mc);
    for (int e = 0; e < N; e++) begin
      int w;
      w = (m_mc[e] > mc) ? m_mc[e] : mc;
      if (m_v[e] && (((a ^ m_tag[e]) >> w) == 0)) m_v[e] = 0;
    end
  endtask

  task automatic do_inv(input int a, input int mc);
    inv_en = 1; inv_addr = AW'(a); inv_mcnt = MW'(mc);
    @(negedge clk);
    inv_en = 0;
    mdl_inv(a, mc);
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < (1 << AW); a++) begin
      lk_req = 1; lk_addr = AW'(a);
      @(negedge clk);
      chk({req, " hit"}, int'(lk_hit), mdl_hit(a));
      chk({req, " code"}, int'(lk_perm), mdl_perm(a));
    end
    lk_req = 0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin : main
    rst_n = 0; lk_req = 0; lk_addr = '0;
    fill_en = 0; fill_addr = '0; fill_mcnt = '0; fill_perm = '0;
    inv_en = 0; inv_addr = '0; inv_mcnt = '0; flush_en = 0;
    for (int e = 0; e < N; e++) begin m_v[e] = 0; m_tag[e] = 0; m_mc[e] = 0; m_p[e] = 0; end
    m_rr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    chk("R11 hit after reset", int'(lk_hit), 0);
    chk("R11 code after reset", int'(lk_perm), 0);
    sweep("R11/R4 empty");

    // R1 R2 R5 R6: nested blocks of different widths, all four codes
    do_fill(8'h40, 4, 1);   // slot 0
    do_fill(8'h44, 0, 2);   // slot 1, inside slot 0
    do_fill(8'h80, 6, 3);   // slot 2
    do_fill(8'h13, 0, 2);   // slot 3
    sweep("R1/R2/R5/R6 first fills");

    // R3: no request -> hit drops, code holds
    lk_req = 1; lk_addr = 8'h85;
    @(negedge clk);
    chk("R3 request hit", int'(lk_hit), 1);
    chk("R3 request code", int'(lk_perm), 3);
    lk_req = 0;
    @(negedge clk);
    chk("R3 idle hit", int'(lk_hit), 0);
    chk("R3 idle code held", int'(lk_perm), 3);

    // R7: full buffer, rotating pointer takes slot 0 then slot 1
    do_fill(8'h20, 3, 2);
    sweep("R7 first rotation");
    do_fill(8'hF0, 2, 1);
    sweep("R7 second rotation");

    // R8: narrow region overlapping a wide entry clears it
    do_inv(8'h81, 1);
    sweep("R8 narrow over wide");
    // R6: the hole is reused before the pointer
    do_fill(8'hC0, 5, 1);
    sweep("R6 hole reuse");

    // R10: lookup in the invalidate cycle sees old state, next sees new
    lk_req = 1; lk_addr = 8'hC7;
    inv_en = 1; inv_addr = 8'hC0; inv_mcnt = 0;
    @(negedge clk);
    inv_en = 0;
    chk("R10 lookup same edge as invalidate", int'(lk_hit), 1);
    mdl_inv(8'hC0, 0);
    @(negedge clk);
    chk("R8 next-cycle lookup after invalidate", int'(lk_hit), 0);
    lk_req = 0;

    // R10: fill with invalidate is dropped
    inv_en = 1; inv_addr = 8'h00; inv_mcnt = 0;
    fill_en = 1; fill_addr = 8'h55; fill_mcnt = 0; fill_perm = 2;
    @(negedge clk);
    inv_en = 0; fill_en = 0;
    mdl_inv(8'h00, 0);
    sweep("R10 fill dropped");

    // R8: whole-space invalidate
    do_inv(8'h00, 8);
    sweep("R8 whole space");

    // R9: flush, with a concurrent fill dropped
    do_fill(8'h10, 4, 2);
    do_fill(8'h90, 2, 3);
    sweep("R1/R2 refill");
    flush_en = 1; fill_en = 1; fill_addr = 8'h33; fill_mcnt = 0; fill_perm = 1;
    @(negedge clk);
    flush_en = 0; fill_en = 0;
    for (int e = 0; e < N; e++) m_v[e] = 0;
    sweep("R9/R10 flush");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule